// File: doc/BRIEF.md
# Byte Stream to Halfword Write Packer

This block turns a byte-granular write request into aligned 16-bit program operations for a halfword flash write engine. A request gives a byte start address and a byte count. The data bytes then arrive one by one on a valid/ready stream. The packer builds each halfword in little-endian order and hands it to the write engine. It waits for the engine to report completion, then moves on to the next halfword.

If the start address is odd, or the count ends halfway into a halfword, the lanes that have no source byte are filled with the bytes already held in flash. The packer fetches these through a single-cycle-latency read port, so the neighbouring data is written back unchanged. The first nonzero status returned by the engine ends the transfer. That status is reported together with the completion pulse.

Back-pressure on the byte stream works as follows. `src_ready` is high only in the cycles in which the packer is waiting for the low or the high lane of the current halfword. A byte is taken only in a cycle where both `src_valid` and `src_ready` are high. The source may hold `src_valid` low for any number of cycles without any effect. Bytes beyond the count, or after an abort, are never accepted.

Top module: `hw_pack`

## Requirements
- R1: The first write address is the start address with bit 0 cleared. Each later write address is 2 greater than the previous one.
- R2: A halfword is packed little-endian: the byte at the even address goes in bits 7:0, and the byte at the odd address goes in bits 15:8.
- R3: With an odd start address, the first halfword takes bits 7:0 from flash at that halfword address and bits 15:8 from the first source byte. With a count of 1, this is the only write.
- R4: A single byte left at the end with an even address becomes bits 7:0 of the last halfword. Bits 15:8 of that halfword keep the flash contents.
- R5: A count of zero completes the transfer with status 0. It issues no write, accepts no byte and performs no read.
- R6: A nonzero `wr_status` ends the transfer when `wr_done` arrives. That value appears on `err_status` at `done`. No further write is issued and no further byte is accepted.
- R7: Each halfword gets exactly one one-cycle `wr_start` pulse. No new pulse is issued until `wr_done` has answered the previous one.
- R8: A byte is consumed only on a cycle where `src_valid` and `src_ready` are both high. `src_ready` is low whenever the block is idle. Exactly the bytes of the halfwords actually written are consumed.
- R9: `done` is a one-cycle pulse that ends every transfer. A successful transfer reports `err_status` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a transfer when idle |
| start_addr | input | AW | Byte start address |
| byte_cnt | input | CW | Number of bytes to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_status | output | SW | Status of the transfer (0 = success) |
| src_valid | input | 1 | Source byte valid |
| src_ready | output | 1 | Packer accepts a source byte |
| src_data | input | 8 | Source byte |
| rd_en | output | 1 | Flash read request |
| rd_addr | output | AW | Flash read byte address (even) |
| rd_data | input | 16 | Flash read data, valid the cycle after `rd_en` |
| wr_start | output | 1 | Start one halfword write |
| wr_addr | output | AW | Halfword write byte address |
| wr_data | output | 16 | Halfword write data |
| wr_done | input | 1 | Write engine finished |
| wr_status | input | SW | Write engine status, valid with `wr_done` |

## Verification
The bench builds the block with AW=10, CW=6 and SW=4. This maps a 1 KiB flash image into a small behavioural memory, and it allows counts up to 63, so head, middle and tail cases all fit into short transfers. The narrow status field makes it easy to inject a chosen failure code on a chosen write and check that it is returned unchanged. A stalling source pattern exercises back-pressure in both lanes.

// File: rtl/hw_pack_pkg.sv
package hw_pack_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PLAN,
    ST_RD,
    ST_RDW,
    ST_LO,
    ST_HI,
    ST_WR,
    ST_WAIT,
    ST_END
  } pack_state_e;

  localparam int LANES = 2;
endpackage

// File: rtl/hw_pack_lane.sv
module hw_pack_lane (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_flash,
  input  logic [7:0] flash_byte,
  input  logic       ld_src,
  input  logic [7:0] src_byte,
  output logic [7:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (ld_src)   q <= src_byte;
    else if (ld_flash) q <= flash_byte;
  end
endmodule

// File: rtl/hw_pack_ctrl.sv
module hw_pack_ctrl
  import hw_pack_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] byte_cnt,
  input  logic          src_valid,
  input  logic          wr_done,
  input  logic [SW-1:0] wr_status,
  output logic          busy,
  output logic          done,
  output logic [SW-1:0] err_status,
  output logic          src_ready,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          ld_flash,
  output logic [LANES-1:0] ld_src,
  output logic          wr_start,
  output logic [AW-1:0] wr_addr
);
  pack_state_e   state, nstate;
  logic [AW-1:0] wp;
  logic [CW-1:0] rem;
  logic          head_odd;
  logic          need_lo, need_hi;
  logic [SW-1:0] stat_q;

  logic plan_lo, plan_hi;
  assign plan_lo = !head_odd && (rem != '0);
  assign plan_hi = head_odd ? (rem != '0) : (rem > CW'(1));

  logic take;
  assign take = src_ready && src_valid;

  always_comb begin
    nstate = state;
    unique case (state)
      ST_IDLE: if (start) nstate = (byte_cnt == '0) ? ST_END : ST_PLAN;
      ST_PLAN: nstate = (plan_lo && plan_hi) ? ST_LO : ST_RD;
      ST_RD:   nstate = ST_RDW;
      ST_RDW:  nstate = need_lo ? ST_LO : ST_HI;
      ST_LO:   if (src_valid) nstate = need_hi ? ST_HI : ST_WR;
      ST_HI:   if (src_valid) nstate = ST_WR;
      ST_WR:   nstate = ST_WAIT;
      ST_WAIT: if (wr_done) begin
                 if (wr_status != '0 || rem == '0) nstate = ST_END;
                 else                              nstate = ST_PLAN;
               end
      ST_END:  nstate = ST_IDLE;
      default: nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wp       <= '0;
      rem      <= '0;
      head_odd <= 1'b0;
      need_lo  <= 1'b0;
      need_hi  <= 1'b0;
      stat_q   <= '0;
    end else begin
      state <= nstate;
      if (state == ST_IDLE && start) begin
        wp       <= {start_addr[AW-1:1], 1'b0};
        rem      <= byte_cnt;
        head_odd <= start_addr[0];
        stat_q   <= '0;
      end
      if (state == ST_PLAN) begin
        need_lo <= plan_lo;
        need_hi <= plan_hi;
      end
      if (take) rem <= rem - CW'(1);
      if (state == ST_WAIT && wr_done) begin
        if (wr_status != '0) begin
          stat_q <= wr_status;
        end else begin
          wp       <= wp + AW'(2);
          head_odd <= 1'b0;
        end
      end
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_END);
  assign err_status = stat_q;
  assign src_ready  = (state == ST_LO) || (state == ST_HI);
  assign rd_en      = (state == ST_RD);
  assign rd_addr    = wp;
  assign ld_flash   = (state == ST_RDW);
  assign ld_src[0]  = (state == ST_LO) && src_valid;
  assign ld_src[1]  = (state == ST_HI) && src_valid;
  assign wr_start   = (state == ST_WR);
  assign wr_addr    = wp;
endmodule

// File: rtl/hw_pack.sv
module hw_pack
  import hw_pack_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] byte_cnt,
  output logic          busy,
  output logic          done,
  output logic [SW-1:0] err_status,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [7:0]    src_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [15:0]   rd_data,
  output logic          wr_start,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data,
  input  logic          wr_done,
  input  logic [SW-1:0] wr_status
);
  logic             ld_flash;
  logic [LANES-1:0] ld_src;

  hw_pack_ctrl #(.AW(AW), .CW(CW), .SW(SW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .byte_cnt   (byte_cnt),
    .src_valid  (src_valid),
    .wr_done    (wr_done),
    .wr_status  (wr_status),
    .busy       (busy),
    .done       (done),
    .err_status (err_status),
    .src_ready  (src_ready),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .ld_flash   (ld_flash),
    .ld_src     (ld_src),
    .wr_start   (wr_start),
    .wr_addr    (wr_addr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hw_pack_lane u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_flash   (ld_flash),
      .flash_byte (rd_data[8*g +: 8]),
      .ld_src     (ld_src[g]),
      .src_byte   (src_data),
      .q          (wr_data[8*g +: 8])
    );
  end
endmodule

// File: rtl/hw_pack_chk.sv
module hw_pack_chk #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] start_addr,
  input logic [CW-1:0] byte_cnt,
  input logic          busy,
  input logic          done,
  input logic [SW-1:0] err_status,
  input logic          src_valid,
  input logic          src_ready,
  input logic [7:0]    src_data,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic [15:0]   rd_data,
  input logic          wr_start,
  input logic [AW-1:0] wr_addr,
  input logic [15:0]   wr_data,
  input logic          wr_done,
  input logic [SW-1:0] wr_status
);
  logic pend, aborted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      aborted <= 1'b0;
    end else begin
      if (wr_start)     pend <= 1'b1;
      else if (wr_done) pend <= 1'b0;
      if (wr_done && wr_status != '0) aborted <= 1'b1;
      else if (done)                  aborted <= 1'b0;
    end
  end

  // R1
  wr_addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> !wr_addr[0]);
  // R7
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> !pend);
  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);
  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start || src_ready) |-> !aborted);
  // R8
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_cnt == '0) |=> done);
endmodule

bind hw_pack hw_pack_chk #(.AW(AW), .CW(CW), .SW(SW)) u_chk (.*);

// File: tb/tb_hw_pack.sv
module tb_hw_pack;
  localparam int AW = 10;
  localparam int CW = 6;
  localparam int SW = 4;
  localparam int HW = 1 << (AW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic          busy, done;
  logic [SW-1:0] err_status;
  logic          src_valid = 1'b0;
  logic          src_ready;
  logic [7:0]    src_data = '0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_data;
  logic          wr_start;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;
  logic          wr_done;
  logic [SW-1:0] wr_status;

  always #2 clk = ~clk;

  hw_pack #(.AW(AW), .CW(CW), .SW(SW)) dut (.*);

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int wr_num = 0;
  int fail_abs = -1;
  logic [SW-1:0] fail_code = 4'h9;
  logic [15:0] mem [HW];

  // behavioural flash: registered read port, write engine with latency
  logic       e_busy;
  logic [1:0] e_lat;
  logic [AW-1:0] e_addr;
  logic [15:0] e_data;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HW; i++) mem[i] <= 16'((i * 16'h3b1d) ^ 16'h5a00);
      rd_data <= '0; wr_done <= 1'b0; wr_status <= '0; e_busy <= 1'b0; e_lat <= '0;
    end else begin
      wr_done <= 1'b0;
      if (rd_en) rd_data <= mem[rd_addr[AW-1:1]];
      if (wr_start) begin
        e_busy <= 1'b1; e_lat <= 2'd2; e_addr <= wr_addr; e_data <= wr_data;
      end else if (e_busy) begin
        if (e_lat == 0) begin
          e_busy  <= 1'b0;
          wr_done <= 1'b1;
          if (wr_num == fail_abs) wr_status <= fail_code;
          else begin
            wr_status <= '0;
            mem[e_addr[AW-1:1]] <= e_data;
          end
          wr_num <= wr_num + 1;
        end else e_lat <= e_lat - 2'd1;
      end
    end
  end

  // scoreboard
  logic [AW+15:0] exp_q [$];

  always @(negedge clk) begin
    if (rst_n && wr_start) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7: unexpected write addr=%h data=%h, expected none", wr_addr, wr_data);
      end else begin
        logic [AW+15:0] e;
        e = exp_q.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          fails++;
          $display("FAIL R1/R2: write addr=%h data=%h, expected addr=%h data=%h",
                   wr_addr, wr_data, e[AW+15:16], e[15:0]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input int b);
    return mem[b >> 1][8*(b & 1) +: 8];
  endfunction

  task automatic run_xfer(input int addr, input int cnt, input int fail_at,
                          input bit gaps, input string req);
    logic [7:0] src [64];
    int used, wp, exp_bytes, nwr, sent, k, exp_stat;
    logic [15:0] hw;
    for (int i = 0; i < 64; i++) src[i] = 8'((addr * 7 + i * 13 + 5) & 255);
    used = 0; wp = addr & ~1; exp_bytes = 0; nwr = 0;
    while (used < cnt && (fail_at < 0 || nwr <= fail_at)) begin
      for (int l = 0; l < 2; l++) begin
        if (wp + l >= addr && used < cnt) begin
          hw[8*l +: 8] = src[used]; used++; exp_bytes++;
        end else hw[8*l +: 8] = mem_byte(wp + l);
      end
      exp_q.push_back({AW'(wp), hw});
      wp += 2; nwr++;
    end
    exp_stat = (fail_at >= 0 && fail_at < nwr) ? int'(fail_code) : 0;
    fail_abs = (fail_at >= 0) ? wr_num + fail_at : -1;
    @(negedge clk);
    start = 1'b1; start_addr = AW'(addr); byte_cnt = CW'(cnt);
    @(negedge clk);
    start = 1'b0;
    sent = 0; k = 0;
    while (!done) begin
      src_valid = (sent < cnt) && !(gaps && (k % 3 == 1));
      src_data  = src[sent < 64 ? sent : 0];
      if (src_valid && src_ready) sent++;
      k++;
      @(negedge clk);
    end
    src_valid = 1'b0;
    check(err_status == SW'(exp_stat), {req, " status"}, int'(err_status), exp_stat);
    check(sent == exp_bytes, {"R8 bytes consumed (", req, ")"}, sent, exp_bytes);
    check(exp_q.size() == 0, {req, " writes issued"}, exp_q.size(), 0);
    @(negedge clk);
    check(!busy, "R9 idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 R8 reset state
    check(!busy && !done && !src_ready && !wr_start && !rd_en,
          "R9 reset outputs quiet", int'({busy, done, src_ready, wr_start, rd_en}), 0);
    run_xfer(16'h010, 6, -1, 1'b0, "R1 R2 aligned");
    run_xfer(16'h021, 5, -1, 1'b1, "R3 odd start");
    run_xfer(16'h041, 4, -1, 1'b1, "R3 R4 odd start even tail");
    run_xfer(16'h061, 1, -1, 1'b0, "R3 head only");
    run_xfer(16'h080, 1, -1, 1'b1, "R4 single tail byte");
    run_xfer(16'h0a0, 0, -1, 1'b0, "R5 zero count");
    run_xfer(16'h0c0, 8, 1, 1'b1, "R6 abort");
    // R6: the region behind the failed write keeps its old contents
    check(mem[(16'h0c4) >> 1] == 16'((16'h0c4/2 * 16'h3b1d) ^ 16'h5a00),
          "R6 no write after abort", int'(mem[16'h0c4 >> 1]), 0);
    run_xfer(16'h101, 9, -1, 1'b1, "R9 recovery after abort");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule